// File: doc/BRIEF.md
# Word-to-Narrow-Bus Memory Packer

This block sits between a processor core and an external memory whose data bus is narrower than the core's 32-bit word. The core presents one logical word address per access, together with a read/write flag and, for writes, a full 32-bit word. The block works out where that word lives on the narrow bus and runs the narrow bus cycles for it. For reads it assembles the returned pieces into one word, and for writes it splits the word into pieces. The core never deals with physical addresses or byte lanes.

The external bus width is fixed at build time: 8 bits gives four bus cycles per word and 16 bits gives two. Inside a configurable external region, the distance of a logical address from the region start is multiplied by the number of pieces per word and added back to the region start. Consecutive logical words therefore occupy adjacent, disjoint groups of physical locations. Each external access takes exactly one cycle, with a read or write strobe high for that cycle. Read data is taken at the end of the strobe cycle.

Top module: `xmem_packer`

## Requirements
- R1: After reset, and while no transfer is running, `core_ready`, `mem_rd` and `mem_wr` are low.
- R2: With `BUS_W`=8, a request for logical address L produces exactly four strobe cycles, back to back, at physical addresses P, P+1, P+2, P+3, where P = BASE + 4·(L − BASE). For example, BASE+0x100 goes to BASE+0x400.
- R3: With `BUS_W`=16, a request for L produces exactly two back-to-back strobe cycles at P and P+1, where P = BASE + 2·(L − BASE).
- R4: For a read, the piece fetched first lands in bits [7:0] in 8-bit mode, or in bits [15:0] in 16-bit mode. Each later piece lands in the next higher lane, so the piece from P+k lands in bits [k·BUS_W +: BUS_W].
- R5: A request sampled high while idle starts strobing in the next cycle. `core_ready` is high for exactly one cycle, the cycle right after the last strobe cycle, and `core_rdata` holds the assembled word in that cycle.
- R6: For a write, lane k of `core_wdata` (bits [k·BUS_W +: BUS_W]) is driven on `mem_wdata` in the strobe cycle at address P+k.
- R7: Logical addresses L and L+1 map to disjoint physical groups. The group for L+1 starts one location after the last location of the group for L, so writing both words and reading them back returns each word intact.
- R8: `core_req` is sampled only when idle. A request raised during a running transfer produces no additional strobes and no additional `core_ready` pulse.
- R9: `mem_rd` and `mem_wr` are never high together. A read transfer raises only `mem_rd` and a write transfer raises only `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req | input | 1 | Core access request, sampled while idle |
| core_we | input | 1 | 1 = write, 0 = read |
| core_addr | input | LADDR_W | Logical word address |
| core_wdata | input | 32 | Word to write |
| core_ready | output | 1 | One-cycle completion pulse |
| core_rdata | output | 32 | Assembled read word, valid with `core_ready` |
| mem_addr | output | LADDR_W+2 | Physical address on the narrow bus |
| mem_wdata | output | BUS_W | Narrow write data |
| mem_rdata | input | BUS_W | Narrow read data, sampled at the end of a read strobe cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |

## Verification
The hardest situation to reach from the ports is a second request that arrives while a transfer is still running. A well-behaved core would not normally raise one. The bench starts an 8-bit read and then pulses `core_req` again, with a different address, during the second strobe cycle. It then counts every strobe and every ready pulse over the following cycles, to show that the stray request left no trace. Overlap between neighbouring logical words cannot be seen in a single access either. The bench therefore writes two adjacent words and reads both back.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    // Transfer sequencer state
    typedef enum logic [1:0] {
        XM_IDLE = 2'd0,
        XM_BUSY = 2'd1,
        XM_DONE = 2'd2
    } xm_state_e;

endpackage

// File: rtl/xmem_addr_map.sv
// Maps a logical word address to the first physical location of its group:
// phys = BASE + ((logical - BASE) << SHIFT)
module xmem_addr_map #(
    parameter int                 LADDR_W     = 24,
    parameter int                 SHIFT       = 2,
    parameter logic [LADDR_W-1:0] REGION_BASE = LADDR_W'('h200000)
) (
    input  logic [LADDR_W-1:0] laddr,
    output logic [LADDR_W+1:0] paddr
);
    localparam int PA_W = LADDR_W + 2;

    logic [LADDR_W-1:0] offset;
    logic [PA_W-1:0]    offset_ext;

    always_comb begin
        offset     = laddr - REGION_BASE;
        offset_ext = {2'b00, offset};
        paddr      = {2'b00, REGION_BASE} + (offset_ext << SHIFT);
    end
endmodule

// File: rtl/xmem_lane_pick.sv
// Selects the narrow lane of a 32-bit word addressed by the beat index.
module xmem_lane_pick #(
    parameter int BUS_W  = 8,
    parameter int BEAT_W = 2
) (
    input  logic [31:0]       word,
    input  logic [BEAT_W-1:0] beat,
    output logic [BUS_W-1:0]  lane
);
    localparam int LANES = 32 / BUS_W;

    logic [LANES-1:0][BUS_W-1:0] lanes;

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_split
            assign lanes[i] = word[i*BUS_W +: BUS_W];
        end
    endgenerate

    assign lane = lanes[beat];
endmodule

// File: rtl/xmem_lane_merge.sv
// Replaces the lane addressed by the beat index with fresh bus data.
module xmem_lane_merge #(
    parameter int BUS_W  = 8,
    parameter int BEAT_W = 2
) (
    input  logic [31:0]       word_in,
    input  logic [BEAT_W-1:0] beat,
    input  logic [BUS_W-1:0]  piece,
    output logic [31:0]       word_out
);
    localparam int LANES = 32 / BUS_W;

    genvar i;
    generate
        for (i = 0; i < LANES; i++) begin : g_lane
            assign word_out[i*BUS_W +: BUS_W] =
                (beat == BEAT_W'(i)) ? piece : word_in[i*BUS_W +: BUS_W];
        end
    endgenerate
endmodule

// File: rtl/xmem_packer.sv
// Logical-word to narrow-bus memory packer (BUS_W = 8 or 16).
module xmem_packer
    import xmem_pkg::*;
#(
    parameter int                 BUS_W       = 8,
    parameter int                 LADDR_W     = 24,
    parameter logic [LADDR_W-1:0] REGION_BASE = LADDR_W'('h200000)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               core_req,
    input  logic               core_we,
    input  logic [LADDR_W-1:0] core_addr,
    input  logic [31:0]        core_wdata,
    output logic               core_ready,
    output logic [31:0]        core_rdata,
    output logic [LADDR_W+1:0] mem_addr,
    output logic [BUS_W-1:0]   mem_wdata,
    input  logic [BUS_W-1:0]   mem_rdata,
    output logic               mem_rd,
    output logic               mem_wr
);
    localparam int PA_W   = LADDR_W + 2;
    localparam int RATIO  = 32 / BUS_W;
    localparam int BEAT_W = $clog2(RATIO);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(RATIO - 1);

    typedef struct packed {
        xm_state_e         st;
        logic [BEAT_W-1:0] beat;
        logic [PA_W-1:0]   grp;
        logic [31:0]       word;
        logic              we;
        logic              rdy;
    } xm_regs_t;

    xm_regs_t r_d, r_q;

    logic [PA_W-1:0] grp_new;
    logic [31:0]     word_merged;
    logic            busy;

    xmem_addr_map #(
        .LADDR_W    (LADDR_W),
        .SHIFT      (BEAT_W),
        .REGION_BASE(REGION_BASE)
    ) u_map (
        .laddr(core_addr),
        .paddr(grp_new)
    );

    xmem_lane_pick #(
        .BUS_W (BUS_W),
        .BEAT_W(BEAT_W)
    ) u_pick (
        .word(r_q.word),
        .beat(r_q.beat),
        .lane(mem_wdata)
    );

    xmem_lane_merge #(
        .BUS_W (BUS_W),
        .BEAT_W(BEAT_W)
    ) u_merge (
        .word_in (r_q.word),
        .beat    (r_q.beat),
        .piece   (mem_rdata),
        .word_out(word_merged)
    );

    always_comb begin
        r_d     = r_q;
        r_d.rdy = 1'b0;
        case (r_q.st)
            XM_IDLE: begin
                if (core_req) begin
                    r_d.st   = XM_BUSY;
                    r_d.beat = '0;
                    r_d.grp  = grp_new;
                    r_d.we   = core_we;
                    r_d.word = core_we ? core_wdata : 32'h0;
                end
            end
            XM_BUSY: begin
                if (!r_q.we) begin
                    r_d.word = word_merged;
                end
                if (r_q.beat == LAST_BEAT) begin
                    r_d.st  = XM_DONE;
                    r_d.rdy = 1'b1;
                end else begin
                    r_d.beat = r_q.beat + BEAT_W'(1);
                end
            end
            XM_DONE: begin
                r_d.st = XM_IDLE;
            end
            default: begin
                r_d.st = XM_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: XM_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy       = (r_q.st == XM_BUSY);
    assign mem_addr   = r_q.grp + PA_W'(r_q.beat);
    assign mem_rd     = busy && !r_q.we;
    assign mem_wr     = busy && r_q.we;
    assign core_ready = r_q.rdy;
    assign core_rdata = r_q.word;

endmodule

// File: rtl/xmem_packer_chk.sv
module xmem_packer_chk #(
    parameter int                 BUS_W       = 8,
    parameter int                 LADDR_W     = 24,
    parameter logic [LADDR_W-1:0] REGION_BASE = LADDR_W'('h200000)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               core_ready,
    input logic               mem_rd,
    input logic               mem_wr,
    input logic [LADDR_W+1:0] mem_addr
);
    localparam int PA_W  = LADDR_W + 2;
    localparam int RATIO = 32 / BUS_W;
    localparam logic [PA_W-1:0] MASK = PA_W'(RATIO - 1);

    logic       strobe;
    logic [3:0] cnt;

    assign strobe = mem_rd || mem_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (core_ready) cnt <= '0;
        else if (strobe)     cnt <= cnt + 4'd1;
    end

    // R9: read and write strobes exclusive
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R5: ready lasts a single cycle
    assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |=> !core_ready);

    // R5: ready comes right after a strobe cycle, never during one
    assert_ready_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |-> ($past(strobe) && !strobe));

    // R2/R3: strobe cycles in a run step the address by one
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && $past(strobe)) |-> (mem_addr == $past(mem_addr) + PA_W'(1)));

    // R7: every group starts on a group boundary relative to the base
    assert_group_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !$past(strobe)) |-> (((mem_addr - {2'b00, REGION_BASE}) & MASK) == '0));

    // R2/R3: number of strobes per transfer equals the packing ratio
    assert_fetch_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |-> (cnt == 4'(RATIO)));

endmodule

bind xmem_packer xmem_packer_chk #(
    .BUS_W      (BUS_W),
    .LADDR_W    (LADDR_W),
    .REGION_BASE(REGION_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .core_ready(core_ready),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr)
);

// File: tb/xmem_packer_tb.sv
`timescale 1ns/1ps
module xmem_packer_tb;
    localparam logic [23:0] BASE = 24'h200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int tests_run = 0;
    int tests_fail = 0;

    // shared core-side stimulus, separate request per instance
    logic        req8 = 1'b0, req16 = 1'b0, we = 1'b0;
    logic [23:0] la = '0;
    logic [31:0] wd = '0;

    logic        rdy8, rdy16, rd8, wr8, rd16, wr16;
    logic [31:0] rdata8, rdata16;
    logic [25:0] addr8, addr16;
    logic [7:0]  wd8, rdd8;
    logic [15:0] wd16, rdd16;

    logic [7:0]  m8  [0:4095];
    logic [15:0] m16 [0:4095];

    xmem_packer #(.BUS_W(8), .LADDR_W(24), .REGION_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .core_req(req8), .core_we(we),
        .core_addr(la), .core_wdata(wd), .core_ready(rdy8), .core_rdata(rdata8),
        .mem_addr(addr8), .mem_wdata(wd8), .mem_rdata(rdd8),
        .mem_rd(rd8), .mem_wr(wr8));

    xmem_packer #(.BUS_W(16), .LADDR_W(24), .REGION_BASE(BASE)) u_dut16 (
        .clk(clk), .rst_n(rst_n), .core_req(req16), .core_we(we),
        .core_addr(la), .core_wdata(wd), .core_ready(rdy16), .core_rdata(rdata16),
        .mem_addr(addr16), .mem_wdata(wd16), .mem_rdata(rdd16),
        .mem_rd(rd16), .mem_wr(wr16));

    // one-cycle external memories, read data valid during the strobe cycle
    assign rdd8  = m8[addr8[11:0]];
    assign rdd16 = m16[addr16[11:0]];

    // bus activity logs
    logic [25:0] lg8_a [0:255];
    logic        lg8_w [0:255];
    logic        lg8_r [0:255];
    logic [25:0] lg16_a [0:255];
    logic        lg16_w [0:255];
    logic        lg16_r [0:255];
    int n8 = 0, n16 = 0, nr8 = 0, nr16 = 0;

    always @(posedge clk) begin
        if (wr8)  m8[addr8[11:0]]   <= wd8;
        if (wr16) m16[addr16[11:0]] <= wd16;
        if (rst_n) begin
            if (rd8 || wr8) begin
                lg8_a[n8[7:0]] <= addr8; lg8_w[n8[7:0]] <= wr8; lg8_r[n8[7:0]] <= rd8;
                n8 <= n8 + 1;
            end
            if (rd16 || wr16) begin
                lg16_a[n16[7:0]] <= addr16; lg16_w[n16[7:0]] <= wr16; lg16_r[n16[7:0]] <= rd16;
                n16 <= n16 + 1;
            end
            if (rdy8)  nr8  <= nr8 + 1;
            if (rdy16) nr16 <= nr16 + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests_run++;
        if (!ok) begin
            tests_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one transfer; lat = negedges after request drop until ready seen
    task automatic xfer(input bit s16, input bit w, input logic [23:0] a, input logic [31:0] d,
                        output logic [31:0] rw, output int lat, output bit held);
        @(negedge clk);
        we = w; la = a; wd = d;
        if (s16) req16 = 1'b1; else req8 = 1'b1;
        @(negedge clk);
        req8 = 1'b0; req16 = 1'b0;
        lat = 0;
        while (!(s16 ? rdy16 : rdy8) && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        rw = s16 ? rdata16 : rdata8;
        @(negedge clk);
        held = s16 ? rdy16 : rdy8;
    endtask

    task automatic t_reset();
        chk(!rdy8 && !rd8 && !wr8, "R1 reset 8-bit", {rdy8, rd8, wr8}, 0);
        chk(!rdy16 && !rd16 && !wr16, "R1 reset 16-bit", {rdy16, rd16, wr16}, 0);
    endtask

    task automatic t_read8();
        logic [31:0] rw; int lat; bit held; int s;
        m8[12'h400] = 8'h11; m8[12'h401] = 8'h22; m8[12'h402] = 8'h33; m8[12'h403] = 8'h44;
        s = n8;
        xfer(1'b0, 1'b0, BASE + 24'h100, 32'h0, rw, lat, held);
        chk(rw == 32'h44332211, "R4 read8 lane order", rw, 32'h44332211);
        chk(lat == 4, "R5 read8 ready timing", lat, 4);
        chk(!held, "R5 read8 ready one cycle", held, 0);
        chk(n8 - s == 4, "R2 read8 strobe count", n8 - s, 4);
        for (int k = 0; k < 4; k++) begin
            chk(lg8_a[s+k] == 26'h200400 + 26'(k), "R2 read8 address", lg8_a[s+k], 26'h200400 + k);
            chk(lg8_r[s+k] && !lg8_w[s+k], "R9 read8 strobe kind", {lg8_r[s+k], lg8_w[s+k]}, 2'b10);
        end
    endtask

    task automatic t_read16();
        logic [31:0] rw; int lat; bit held; int s;
        m16[12'h006] = 16'hAAAA; m16[12'h007] = 16'hBBBB;
        s = n16;
        xfer(1'b1, 1'b0, BASE + 24'h3, 32'h0, rw, lat, held);
        chk(rw == 32'hBBBBAAAA, "R4 read16 lane order", rw, 32'hBBBBAAAA);
        chk(lat == 2, "R5 read16 ready timing", lat, 2);
        chk(!held, "R5 read16 ready one cycle", held, 0);
        chk(n16 - s == 2, "R3 read16 strobe count", n16 - s, 2);
        chk(lg16_a[s] == 26'h200006 && lg16_a[s+1] == 26'h200007, "R3 read16 addresses",
            {lg16_a[s], lg16_a[s+1]}, {26'h200006, 26'h200007});
    endtask

    task automatic t_write8();
        logic [31:0] rw; int lat; bit held; int s;
        s = n8;
        xfer(1'b0, 1'b1, BASE + 24'h10, 32'hDEADBEEF, rw, lat, held);
        chk({m8[12'h043], m8[12'h042], m8[12'h041], m8[12'h040]} == 32'hDEADBEEF,
            "R6 write8 lanes", {m8[12'h043], m8[12'h042], m8[12'h041], m8[12'h040]}, 32'hDEADBEEF);
        chk(lat == 4, "R5 write8 ready timing", lat, 4);
        for (int k = 0; k < 4; k++)
            chk(lg8_w[s+k] && !lg8_r[s+k] && lg8_a[s+k] == 26'h200040 + 26'(k),
                "R9 write8 strobe kind and R6 address", lg8_a[s+k], 26'h200040 + k);
    endtask

    task automatic t_write16();
        logic [31:0] rw; int lat; bit held;
        xfer(1'b1, 1'b1, BASE + 24'h20, 32'hCAFE1234, rw, lat, held);
        chk(m16[12'h040] == 16'h1234 && m16[12'h041] == 16'hCAFE, "R6 write16 lanes",
            {m16[12'h041], m16[12'h040]}, 32'hCAFE1234);
        chk(lat == 2, "R5 write16 ready timing", lat, 2);
    endtask

    task automatic t_adjacent();
        logic [31:0] rw; int lat; bit held; int s;
        s = n8;
        xfer(1'b0, 1'b1, BASE + 24'h50, 32'h01020304, rw, lat, held);
        xfer(1'b0, 1'b1, BASE + 24'h51, 32'hA0B0C0D0, rw, lat, held);
        chk(lg8_a[s+4] == lg8_a[s+3] + 26'd1, "R7 next group follows previous",
            lg8_a[s+4], lg8_a[s+3] + 1);
        xfer(1'b0, 1'b0, BASE + 24'h50, 32'h0, rw, lat, held);
        chk(rw == 32'h01020304, "R7 first word intact", rw, 32'h01020304);
        xfer(1'b0, 1'b0, BASE + 24'h51, 32'h0, rw, lat, held);
        chk(rw == 32'hA0B0C0D0, "R7 second word intact", rw, 32'hA0B0C0D0);
    endtask

    task automatic t_busy_req();
        int s, r;
        s = n8; r = nr8;
        @(negedge clk);
        we = 1'b0; la = BASE + 24'h100; req8 = 1'b1;
        @(negedge clk);
        req8 = 1'b0;
        @(negedge clk);
        la = BASE + 24'h200; req8 = 1'b1;    // stray request mid-transfer
        @(negedge clk);
        req8 = 1'b0;
        repeat (12) @(negedge clk);
        chk(n8 - s == 4, "R8 no extra strobes", n8 - s, 4);
        chk(nr8 - r == 1, "R8 single ready pulse", nr8 - r, 1);
        chk(!rd8 && !wr8 && !rdy8, "R1 idle after transfer", {rd8, wr8, rdy8}, 0);
    endtask

    initial begin
        #(200000 * 5);
        tests_run++;
        tests_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) begin
            m8[i] = 8'h0;
            m16[i] = 16'h0;
        end
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read8();
        t_read16();
        t_write8();
        t_write16();
        t_adjacent();
        t_busy_req();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end
endmodule